// File: doc/BRIEF.md
# Interpolating Apodization Front-End

This block feeds one receive channel of a delay-and-sum beamformer. Several consumers, one per scanline, each need a steady supply of weighted echo samples at four times the stored sample rate. The block keeps a separate read position in the channel's sample memory for each consumer. It chooses one requesting consumer at a time and reads five consecutive 12-bit raw samples starting at that consumer's position. From those samples it produces sixteen linearly interpolated points. It scales each point by the channel's apodization weight and hands the results out one by one over a valid/ready handshake. The consumer's position then moves forward by four raw samples.

The weight register and the position table change only while no burst is in flight. A bundle controller loads a new weight, or rewinds every consumer to address zero, between scanline bundles. Positions at or beyond the memory depth read as zero.

Top module: `interp_apod_fe`

## Requirements
- R1: While rst_ni is low, gnt_o is all zero, out_valid_o is 0 and mem_rd_o is 0. All consumer positions reset to 0, and the internal "last granted" index resets to NC-1, so consumer 0 has first priority.
- R2: In an idle cycle with at least one req_i bit set and rewind_i low, the block grants the first requesting consumer at or after (last granted + 1) modulo NC. gnt_o then shows that consumer as a one-hot vector from the next cycle on.
- R3: gnt_o is one-hot or zero. A grant stays unchanged until the 16th output handshake of its burst, and gnt_o returns to zero in the cycle after that handshake.
- R4: After a grant, the block issues one read per cycle for five cycles, to addresses p, p+1, p+2, p+3 and p+4, where p is the granted consumer's own position. Read data is taken from mem_data_i in the cycle after each read. After the burst, p has grown by 4. Other consumers' positions do not change.
- R5: Output number n (0..15, in delivery order) uses s = n/4 and j = n mod 4. The interpolated value is v = x[s] + floor(j*(x[s+1]-x[s])/4), where x[0..4] are the five fetched samples in two's complement.
- R6: Each delivered value is floor((v*w + 2^(WF-1)) / 2^WF). Here w is the unsigned weight and WF = 10 by default, so w = 1024 stands for a gain of 1.0.
- R7: A scaled value above 2047 is delivered as 2047. A scaled value below -2048 is delivered as -2048.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value.
- R9: A fetch address at or beyond DEPTH issues no read (mem_rd_o stays 0) and supplies 0 as its sample. A position at or beyond DEPTH does not advance.
- R10: weight_we_i loads weight_i only in an idle cycle. During a burst, weight_we_i has no effect on the values delivered.
- R11: rewind_i in an idle cycle sets every consumer's position to 0 and blocks any grant in that cycle. During a burst, rewind_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NC | Request line per consumer |
| gnt_o | output | NC | One-hot owner of the current burst |
| weight_we_i | input | 1 | Load strobe for the apodization weight (idle only) |
| weight_i | input | WW | Unsigned apodization weight, WF fraction bits |
| rewind_i | input | 1 | Reset all consumer positions to 0 (idle only) |
| mem_rd_o | output | 1 | Sample memory read enable |
| mem_addr_o | output | $clog2(DEPTH) | Sample memory read address |
| mem_data_i | input | SW | Read data, valid the cycle after mem_rd_o |
| out_valid_o | output | 1 | Weighted sample available |
| out_ready_i | input | 1 | Consumer accepts the sample |
| out_data_o | output | SW | Weighted interpolated sample, signed |

## Verification
The assertions assume that the sample memory returns data exactly one cycle after each read. They also assume that reset holds the block in its idle state, so the properties that compare with earlier cycles see a clean history. The stimulus meets the first assumption through a synchronous memory model in the bench. It draws request vectors, ready, weight loads and rare rewinds from a seeded generator, and it toggles inputs only at falling edges. The weight range reaches about four times unity, so saturation occurs. The memory is kept shallow, so consumers regularly run past its end and read zeros.

// File: rtl/interp_apod_pkg.sv
package interp_apod_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DRAIN, ST_SEND} fe_state_e;
  localparam int unsigned RAW_PER_BURST = 4;
  localparam int unsigned UPSAMPLE      = 4;
  localparam int unsigned NSLOT         = RAW_PER_BURST + 1;
  localparam int unsigned NOUT          = RAW_PER_BURST * UPSAMPLE;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned NC = 16,
  localparam int unsigned IW = $clog2(NC)
) (
  input  logic [NC-1:0] req_i,
  input  logic [IW-1:0] last_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int unsigned k = 1; k <= NC; k++) begin
      int unsigned cand;
      cand = (int'(last_i) + k) % NC;
      if (!any_o && req_i[cand]) begin
        any_o = 1'b1;
        idx_o = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/interp_scale.sv
module interp_scale #(
  parameter int unsigned SW = 12,
  parameter int unsigned WW = 12,
  parameter int unsigned WF = 10,
  localparam int unsigned PW = SW + WW + 1
) (
  input  logic [SW-1:0] x0_i,
  input  logic [SW-1:0] x1_i,
  input  logic [1:0]    phase_i,
  input  logic [WW-1:0] weight_i,
  output logic [SW-1:0] y_o
);
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (WF - 1);
  localparam logic signed [PW-1:0] SMAX = PW'((1 << (SW - 1)) - 1);
  localparam logic signed [PW-1:0] SMIN = -(PW'(1) <<< (SW - 1));

  logic signed [SW:0]   diff;
  logic signed [SW+2:0] step;
  logic signed [SW+2:0] interp;
  logic signed [PW-1:0] prod, rnd;

  assign diff   = $signed({x1_i[SW-1], x1_i}) - $signed({x0_i[SW-1], x0_i});
  assign step   = $signed({{2{diff[SW]}}, diff}) * $signed({{(SW+1){1'b0}}, phase_i});
  assign interp = $signed({{3{x0_i[SW-1]}}, x0_i}) + (step >>> 2);
  assign prod   = $signed({{(WW+1){interp[SW-1]}}, interp[SW-1:0]})
                * $signed({{(SW+1){1'b0}}, weight_i});
  assign rnd    = (prod + RND) >>> WF;

  always_comb begin
    if (rnd > SMAX)      y_o = SMAX[SW-1:0];
    else if (rnd < SMIN) y_o = SMIN[SW-1:0];
    else                 y_o = rnd[SW-1:0];
  end
endmodule

// File: rtl/interp_apod_fe.sv
module interp_apod_fe
  import interp_apod_pkg::*;
#(
  parameter int unsigned NC    = 16,
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned SW    = 12,
  parameter int unsigned WW    = 12,
  parameter int unsigned WF    = 10,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PTRW = AW + 1,
  localparam int unsigned IW   = $clog2(NC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NC-1:0] req_i,
  output logic [NC-1:0] gnt_o,
  input  logic          weight_we_i,
  input  logic [WW-1:0] weight_i,
  input  logic          rewind_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [SW-1:0] mem_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [SW-1:0] out_data_o
);
  localparam logic [PTRW-1:0] DEPTH_P = PTRW'(DEPTH);

  fe_state_e       st_q;
  logic [3:0]      cnt_q;
  logic [IW-1:0]   owner_q, last_q, pick_idx;
  logic            pick_any;
  logic [WW-1:0]   weight_q;
  logic [PTRW-1:0] pos_q [NC];
  logic [SW-1:0]   x_q [NSLOT];
  logic            rd_pend_q, rd_zero_q;
  logic [2:0]      rd_slot_q;
  logic [PTRW-1:0] cur_pos, fetch_addr;
  logic            in_range, last_out;

  rr_pick #(.NC(NC)) u_pick (
    .req_i(req_i), .last_i(last_q), .any_o(pick_any), .idx_o(pick_idx)
  );

  assign cur_pos    = pos_q[owner_q];
  assign fetch_addr = cur_pos + PTRW'(cnt_q);
  assign in_range   = fetch_addr < DEPTH_P;
  assign mem_rd_o   = (st_q == ST_FETCH) && in_range;
  assign mem_addr_o = fetch_addr[AW-1:0];
  assign last_out   = (st_q == ST_SEND) && out_ready_i && (cnt_q == 4'(NOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      owner_q  <= '0;
      last_q   <= IW'(NC - 1);
      weight_q <= '0;
      gnt_o    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (weight_we_i) weight_q <= weight_i;
          if (!rewind_i && pick_any) begin
            owner_q <= pick_idx;
            last_q  <= pick_idx;
            gnt_o   <= NC'(1) << pick_idx;
            cnt_q   <= '0;
            st_q    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (cnt_q == 4'(RAW_PER_BURST)) st_q <= ST_DRAIN;
          else cnt_q <= cnt_q + 4'd1;
        end
        ST_DRAIN: begin
          cnt_q <= '0;
          st_q  <= ST_SEND;
        end
        ST_SEND: begin
          if (out_ready_i) begin
            cnt_q <= cnt_q + 4'd1;
            if (last_out) begin
              st_q  <= ST_IDLE;
              gnt_o <= '0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // per-consumer positions
  for (genvar c = 0; c < NC; c++) begin : g_pos
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_q[c] <= '0;
      else if (st_q == ST_IDLE && rewind_i) pos_q[c] <= '0;
      else if (st_q == ST_FETCH && cnt_q == 4'(RAW_PER_BURST) && owner_q == IW'(c)
               && pos_q[c] < DEPTH_P)
        pos_q[c] <= pos_q[c] + PTRW'(RAW_PER_BURST);
    end
  end

  // read return capture, one cycle after the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_zero_q <= 1'b0;
      rd_slot_q <= '0;
    end else begin
      rd_pend_q <= (st_q == ST_FETCH);
      rd_zero_q <= !in_range;
      rd_slot_q <= cnt_q[2:0];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) x_q[s] <= '0;
      else if (rd_pend_q && rd_slot_q == 3'(s)) x_q[s] <= rd_zero_q ? '0 : mem_data_i;
    end
  end

  logic [2:0] seg;
  assign seg = {1'b0, cnt_q[3:2]};

  interp_scale #(.SW(SW), .WW(WW), .WF(WF)) u_scale (
    .x0_i(x_q[seg]), .x1_i(x_q[seg + 3'd1]), .phase_i(cnt_q[1:0]),
    .weight_i(weight_q), .y_o(out_data_o)
  );

  assign out_valid_o = (st_q == ST_SEND);

  p_gnt_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !last_out) |=> $stable(gnt_o));
  p_gnt_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_out |=> gnt_o == '0);
  p_gnt_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && $past(gnt_o) == '0) |-> ($past(req_i) & gnt_o) != '0);
  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  p_weight_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(weight_q));
  p_rd_owned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (gnt_o != '0 && !out_valid_o));
endmodule

// File: tb/interp_apod_fe_test.sv
module interp_apod_fe_test;
  localparam int PERIOD = 10;
  localparam int NC = 16;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CYCLES = 12000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] req = '0, gnt;
  logic we = 1'b0, rew = 1'b0, rdy = 1'b0, mrd, oval;
  logic [11:0] wgt_in = '0, mdata = '0, odata;
  logic [AW-1:0] maddr;
  logic [11:0] mem [DEPTH];

  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  interp_apod_fe #(.NC(NC), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt),
    .weight_we_i(we), .weight_i(wgt_in), .rewind_i(rew),
    .mem_rd_o(mrd), .mem_addr_o(maddr), .mem_data_i(mdata),
    .out_valid_o(oval), .out_ready_i(rdy), .out_data_o(odata)
  );

  always_ff @(posedge clk) if (mrd) mdata <= mem[maddr];

  function automatic int expect_val(int x0, int x1, int j, int w);
    int v, p;
    v = x0 + ((j * (x1 - x0)) >>> 2);
    p = (v * w + 512) >>> 10;
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return p;
  endfunction

  task automatic check(bit ok, string req_tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // bench model
  int st = 0, k = 0, n = 0, owner = 0, last = NC - 1, wmod = 0;
  int pos [NC];
  int xs [5];
  bit prev_hold = 0;
  logic [11:0] prev_data;

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = 12'($urandom);
    mem[0] = 12'h7ff; mem[1] = 12'h800; mem[2] = 12'h7ff; mem[3] = 12'h000; mem[4] = 12'h400;
    for (int i = 0; i < NC; i++) pos[i] = 0;
    repeat (3) @(negedge clk);
    check(gnt == '0 && !oval && !mrd, "R1 reset", {gnt, oval, mrd}, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      logic [NC-1:0] rn;
      logic rdn, wen, rwn;
      logic [11:0] wn;
      @(negedge clk);
      // output checks
      check(gnt == (st != 0 ? NC'(1) << owner : '0), "R2,R3 grant", gnt,
            st != 0 ? (1 << owner) : 0);
      check(oval == (st == 3), "R3 valid", oval, st == 3);
      if (st == 1) begin
        bit inr;
        inr = (pos[owner] + k) < DEPTH;
        check(mrd == inr, "R4,R9,R11 read enable", mrd, inr);
        if (inr) check(maddr == AW'(pos[owner] + k), "R4,R11 address", maddr, pos[owner] + k);
      end else check(!mrd, "R4 no read", mrd, 0);
      if (st == 3) begin
        int e;
        e = expect_val(xs[n / 4], xs[n / 4 + 1], n % 4, wmod);
        check($signed(odata) == e, "R5,R6,R7,R9,R10 data", $signed(odata), e);
        if (prev_hold) check(odata == prev_data, "R8 hold", odata, prev_data);
      end
      // new inputs
      if (cyc < 400) begin
        rn = NC'(16'h0021); wen = (cyc == 0); wn = 12'd1024; rwn = 0; rdn = 1;
      end else begin
        rn = NC'($urandom) & NC'($urandom);
        rdn = ($urandom % 10) < 7;
        wen = ($urandom % 8) == 0;
        wn = 12'($urandom % 4400);
        rwn = ($urandom % 150) == 0;
      end
      req = rn; rdy = rdn; we = wen; wgt_in = wn; rew = rwn;
      prev_hold = (st == 3) && !rdn;
      prev_data = odata;
      // model of the coming edge
      case (st)
        0: begin
          if (wen) wmod = int'(wn);
          if (rwn) for (int i = 0; i < NC; i++) pos[i] = 0;
          else if (rn != '0) begin
            for (int i = 1; i <= NC; i++) begin
              int c;
              c = (last + i) % NC;
              if (rn[c]) begin owner = c; break; end
            end
            last = owner; st = 1; k = 0;
          end
        end
        1: begin
          xs[k] = (pos[owner] + k < DEPTH) ? int'($signed(mem[pos[owner] + k])) : 0;
          if (k == 4) begin
            if (pos[owner] < DEPTH) pos[owner] += 4;
            st = 2;
          end else k++;
        end
        2: begin st = 3; n = 0; end
        default: if (rdn) begin
          if (n == 15) st = 0; else n++;
        end
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule